// File: doc/BRIEF.md
# DMA Channel Graceful-Stop Controller

This block runs one DMA channel that moves data with a read from a source address followed by a write to a destination address. It also decides how the channel winds down. A transfer count loaded at enable limits the run. An end condition can also stop the channel early: the `end_cond` input, or software pulling `en` low. The channel does not abort on an end condition. It stops taking new requests at the next sampling point and lets every transfer it has already taken run to completion. Only then does it report idle.

Requests are taken only at sampling points. A sampling point is any cycle in which the channel is active and the bus sequencer holds no phase, so `bus_req` is low. These points fall between the end of one read/write pair and the start of the next read.

There are two request modes and two detection styles:
- **Cycle-steal mode:** each taken request causes exactly one transfer.
- **Burst mode with edge detection:** one edge starts a run of transfers. The stop is still checked only at the same sampling points.
- **Level detection:** in either mode, the request is sampled active-high at each sampling point.

A sticky flag records that the run ended because of an end condition rather than the count running out. A counter of accepted but unfinished transfers lets the channel tell when it has drained.

Top module: `dma_gstop`

## Requirements
- R1: A rising edge of `en` while `idle` is high loads `count_init`, `src_base` and `dst_base`, and clears `stop_flag`. From the next cycle `idle` is low.
- R2: Requests are taken only at sampling points (active and `bus_req` low). With `level_mode`=1, `xfer_req` high at a sampling point is one request. With `level_mode`=0, a rising edge of `xfer_req` (compared with its value one cycle earlier) is held until the next sampling point. In cycle-steal mode (`burst_mode`=0) each held edge yields exactly one transfer.
- R3: With `burst_mode`=1 and `level_mode`=0, a single rising edge causes a transfer to be taken at every later sampling point, until the channel stops.
- R4: An end condition (`end_cond` high, or `en` low, at any cycle while active) freezes acceptance at the next sampling point and sets `stop_flag`. No request is taken after that, in every mode.
- R5: Every taken transfer completes before `idle` rises. In a continuous run, an end condition seen during the read of transfer k gives exactly k+1 transfers.
- R6: Once a read completes, the matching write follows on the next cycle, even if the end condition arrived during that read.
- R7: At most `count_init` transfers run. When the count is used up, the channel goes idle after the last write and `stop_flag` stays 0, whatever `end_cond` or `xfer_req` do afterwards.
- R8: Transfer i (from 0) reads at `src_base`+i (`bus_we`=0) and then writes at `dst_base`+i (`bus_we`=1). Each phase holds its address and direction until a cycle with `bus_ready` high.
- R9: After every write completes, `bus_req` is low for at least one cycle.
- R10: `idle` is high only when no taken transfer is outstanding, and then `bus_req` is low. `stop_flag` stays set until the next R1 start.
- R11: While `rst` is high and after it, `idle`=1, `bus_req`=0 and `stop_flag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Channel enable; rising edge starts a run, low acts as an end condition |
| burst_mode | input | 1 | 1 = burst mode, 0 = cycle-steal mode |
| level_mode | input | 1 | 1 = level-detected request, 0 = edge-detected request |
| xfer_req | input | 1 | Transfer request |
| end_cond | input | 1 | End condition other than count exhaustion |
| count_init | input | CNT_W | Number of transfers allowed in the run |
| src_base | input | ADDR_W | First source address |
| dst_base | input | ADDR_W | First destination address |
| bus_req | output | 1 | Bus phase active |
| bus_we | output | 1 | 1 = write phase, 0 = read phase |
| bus_addr | output | ADDR_W | Address of the current phase |
| bus_ready | input | 1 | Current phase completes at this edge |
| idle | output | 1 | Channel inactive with nothing outstanding |
| stop_flag | output | 1 | Sticky: run ended by an end condition |

## Verification
Some properties are checked on every cycle:
- a completed read is always followed by its write;
- the bus drops after each write and holds steady through wait states;
- no request is taken once frozen, and the outstanding count never underflows;
- the channel never goes idle with work outstanding;
- `stop_flag` only clears on a start.

Other behaviour needs whole scenarios and is shown only by the bench. This includes the exact number of transfers that run after an end condition in each mode and detection style, and one transfer per edge in cycle-steal mode. It also includes count exhaustion leaving the flag clear, and the address sequence.

// File: rtl/dma_gstop_pkg.sv
package dma_gstop_pkg;

    // Bus sequencer phase
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } bus_phase_e;

    // Channel request configuration
    typedef struct packed {
        logic burst;
        logic level;
    } chan_mode_t;

    // Request presented at a sampling point, by mode
    function automatic logic wants_xfer(chan_mode_t m, logic req_lvl,
                                        logic edge_held, logic run_on);
        if (m.level) return req_lvl;
        if (m.burst) return edge_held | run_on;
        return edge_held;
    endfunction

endpackage

// File: rtl/dma_gstop_reqdet.sv
module dma_gstop_reqdet
    import dma_gstop_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       active,
    input  logic       frozen,
    input  logic       accept,
    input  chan_mode_t mode,
    input  logic       req,
    output logic       want
);

    logic req_q;
    logic edge_held;
    logic run_on;
    logic rise;

    assign rise = req && !req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q     <= 1'b0;
            edge_held <= 1'b0;
            run_on    <= 1'b0;
        end else begin
            req_q <= req;
            if (start) begin
                edge_held <= 1'b0;
                run_on    <= 1'b0;
            end else begin
                if (accept)
                    edge_held <= 1'b0;
                if (active && !frozen && rise)
                    edge_held <= 1'b1;
                if (frozen)
                    run_on <= 1'b0;
                else if (accept && mode.burst && !mode.level)
                    run_on <= 1'b1;
            end
        end
    end

    assign want = wants_xfer(mode, req, edge_held, run_on);

    // R2: in cycle-steal edge mode one edge is consumed by one acceptance
    assert_edge_consumed_R2: assert property (@(posedge clk) disable iff (rst)
        (accept && !mode.level && !mode.burst && !rise && !start) |=> !edge_held);

endmodule

// File: rtl/dma_gstop_gate.sv
module dma_gstop_gate #(
    parameter int CNT_W  = 8,
    parameter int PEND_W = 2   // at most two outstanding: one in flight, one taken at idle
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             en,
    input  logic             end_cond,
    input  logic [CNT_W-1:0] count_init,
    input  logic             want,
    input  logic             at_idle,
    input  logic             wdone,
    output logic             accept,
    output logic             frozen,
    output logic             active,
    output logic             sticky,
    output logic             pend_nz
);

    logic              stop_held;
    logic [CNT_W-1:0]  remain;
    logic [PEND_W-1:0] pend;
    logic              sample;
    logic              stop_now;
    logic              can_take;
    logic              freeze_now;
    logic              finish;

    assign sample     = active && at_idle;
    assign stop_now   = stop_held || end_cond || !en;
    assign can_take   = sample && !frozen && (remain != '0);
    assign freeze_now = can_take && stop_now;
    assign accept     = can_take && !stop_now && want;
    assign finish     = sample && (pend == '0) && (frozen || remain == '0);
    assign pend_nz    = (pend != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_held <= 1'b0;
            remain    <= '0;
            pend      <= '0;
            frozen    <= 1'b0;
            active    <= 1'b0;
            sticky    <= 1'b0;
        end else if (start) begin
            stop_held <= 1'b0;
            remain    <= count_init;
            pend      <= '0;
            frozen    <= 1'b0;
            active    <= 1'b1;
            sticky    <= 1'b0;
        end else begin
            if (active && (end_cond || !en))
                stop_held <= 1'b1;
            if (freeze_now) begin
                frozen <= 1'b1;
                sticky <= 1'b1;
            end
            if (accept) begin
                remain <= remain - 1'b1;
                pend   <= pend + 1'b1;
            end
            if (wdone)
                pend <= pend - 1'b1;
            if (finish)
                active <= 1'b0;
        end
    end

    // R4: nothing is taken once frozen
    assert_no_take_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        frozen |-> !accept);

    // R5: a write never completes without an outstanding transfer
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        wdone |-> pend_nz);

    // R5: the channel drops active only when drained
    assert_drained_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> (pend == '0));

    // R10: sticky flag clears only on a start
    assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(sticky) |-> $past(start));

endmodule

// File: rtl/dma_gstop_seq.sv
module dma_gstop_seq
    import dma_gstop_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              pend_nz,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic              bus_ready,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              wdone,
    output logic              at_idle
);

    bus_phase_e        ph;
    logic [ADDR_W-1:0] src_ptr;
    logic [ADDR_W-1:0] dst_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            src_ptr <= '0;
            dst_ptr <= '0;
        end else begin
            if (start) begin
                src_ptr <= src_base;
                dst_ptr <= dst_base;
            end
            unique case (ph)
                PH_IDLE:  if (pend_nz)   ph <= PH_READ;
                PH_READ:  if (bus_ready) ph <= PH_WRITE;
                PH_WRITE: if (bus_ready) begin
                    ph      <= PH_IDLE;
                    src_ptr <= src_ptr + 1'b1;
                    dst_ptr <= dst_ptr + 1'b1;
                end
                default:  ph <= PH_IDLE;
            endcase
        end
    end

    assign bus_req  = (ph != PH_IDLE);
    assign bus_we   = (ph == PH_WRITE);
    assign bus_addr = (ph == PH_WRITE) ? dst_ptr : src_ptr;
    assign wdone    = (ph == PH_WRITE) && bus_ready;
    assign at_idle  = (ph == PH_IDLE);

    // R6: a completed read is always followed by its write
    assert_write_follows_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && bus_ready) |=> (bus_req && bus_we));

    // R9: bus released after each write
    assert_bus_release_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_ready) |=> !bus_req);

    // R8: a stalled phase holds address and direction
    assert_hold_stall_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_we) && $stable(bus_addr)));

endmodule

// File: rtl/dma_gstop.sv
module dma_gstop
    import dma_gstop_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int PEND_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              burst_mode,
    input  logic              level_mode,
    input  logic              xfer_req,
    input  logic              end_cond,
    input  logic [CNT_W-1:0]  count_init,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ready,
    output logic              idle,
    output logic              stop_flag
);

    logic       en_q;
    logic       start;
    logic       want;
    logic       accept;
    logic       frozen;
    logic       active;
    logic       pend_nz;
    logic       wdone;
    logic       at_idle;
    chan_mode_t mode;

    assign mode  = '{burst: burst_mode, level: level_mode};
    assign start = en && !en_q && !active;

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= en;
    end

    dma_gstop_reqdet u_reqdet (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .active (active),
        .frozen (frozen),
        .accept (accept),
        .mode   (mode),
        .req    (xfer_req),
        .want   (want)
    );

    dma_gstop_gate #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_gate (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .en         (en),
        .end_cond   (end_cond),
        .count_init (count_init),
        .want       (want),
        .at_idle    (at_idle),
        .wdone      (wdone),
        .accept     (accept),
        .frozen     (frozen),
        .active     (active),
        .sticky     (stop_flag),
        .pend_nz    (pend_nz)
    );

    dma_gstop_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .pend_nz   (pend_nz),
        .src_base  (src_base),
        .dst_base  (dst_base),
        .bus_ready (bus_ready),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .wdone     (wdone),
        .at_idle   (at_idle)
    );

    assign idle = !active;

    // R10: an idle channel never drives the bus
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        idle |-> !bus_req);

endmodule

// File: tb/test_dma_gstop.sv
module test_dma_gstop;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int CNT_W      = 8;
    localparam logic [ADDR_W-1:0] SRC0 = 16'h0040;
    localparam logic [ADDR_W-1:0] DST0 = 16'h0800;

    typedef struct packed {
        logic       burst;
        logic       level;
        logic       by_en;   // end condition given by dropping en
        logic       stall;   // bus_ready only on odd cycles
        logic [7:0] cnt;
        logic [3:0] npulse;  // edge pulses, 6 cycles apart
        logic [3:0] endk;    // end during read of transfer k (0 = never)
        logic [7:0] exp_w;
        logic       exp_stk;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'd3,  4'd0, 4'd0, 8'd3, 1'b0}, // R7 count ends run
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'd10, 4'd0, 4'd2, 8'd3, 1'b1}, // R4 R5 level steal
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'd10, 4'd0, 4'd1, 8'd2, 1'b1}, // R5 with wait states
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'd5,  4'd1, 4'd1, 8'd1, 1'b1}, // R2 one edge one transfer
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'd2,  4'd2, 4'd0, 8'd2, 1'b0}, // R2 R7 two edges
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'd10, 4'd1, 4'd3, 8'd4, 1'b1}, // R3 burst edge stop
        '{1'b1, 1'b0, 1'b0, 1'b1, 8'd4,  4'd1, 4'd0, 8'd4, 1'b0}, // R3 R7 burst edge count
        '{1'b1, 1'b1, 1'b0, 1'b0, 8'd10, 4'd0, 4'd1, 8'd2, 1'b1}, // R4 burst level
        '{1'b0, 1'b1, 1'b1, 1'b0, 8'd10, 4'd0, 4'd2, 8'd3, 1'b1}, // R4 en dropped
        '{1'b0, 1'b0, 1'b0, 1'b1, 8'd5,  4'd2, 4'd2, 8'd2, 1'b1}  // R2 R5 edge with stalls
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              en;
    logic              burst_mode;
    logic              level_mode;
    logic              xfer_req;
    logic              end_cond;
    logic [CNT_W-1:0]  count_init;
    logic [ADDR_W-1:0] src_base;
    logic [ADDR_W-1:0] dst_base;
    logic              bus_req;
    logic              bus_we;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_ready;
    logic              idle;
    logic              stop_flag;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_gstop i_dma_gstop (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .burst_mode (burst_mode),
        .level_mode (level_mode),
        .xfer_req   (xfer_req),
        .end_cond   (end_cond),
        .count_init (count_init),
        .src_base   (src_base),
        .dst_base   (dst_base),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_ready  (bus_ready),
        .idle       (idle),
        .stop_flag  (stop_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_case(input vec_t v);
        int  cyc = 0;
        int  rd = 0;
        int  wr = 0;
        int  bad_addr = 0;
        int  bad_gap = 0;
        bit  fired = 0;
        bit  wr_prev = 0;
        bit  timeout = 0;
        @(negedge clk);
        burst_mode = v.burst;
        level_mode = v.level;
        count_init = v.cnt;
        end_cond   = 1'b0;
        xfer_req   = 1'b0;
        bus_ready  = 1'b0;
        en         = 1'b0;
        @(negedge clk);
        en = 1'b1;
        while (1) begin
            @(negedge clk);
            cyc++;
            if (v.level)
                xfer_req = 1'b1;
            else
                xfer_req = (cyc >= 2) && ((cyc - 2) % 6 == 0) && ((cyc - 2) / 6 < int'(v.npulse));
            end_cond = 1'b0;
            if (bus_req && !bus_we && !fired && v.endk != 0 && rd == int'(v.endk) - 1) begin
                fired = 1;
                if (v.by_en) en = 1'b0;
                else         end_cond = 1'b1;
            end
            if (wr_prev && bus_req) bad_gap++;
            if (bus_req) begin
                if (bus_we && bus_addr != DST0 + ADDR_W'(wr)) bad_addr++;
                if (!bus_we && bus_addr != SRC0 + ADDR_W'(rd)) bad_addr++;
            end
            bus_ready = bus_req && (!v.stall || (cyc % 2 == 1));
            wr_prev = bus_ready && bus_we;
            if (bus_ready && !bus_we) rd++;
            if (bus_ready && bus_we) wr++;
            if (cyc > 2 && idle) break;
            if (cyc > 3000) begin timeout = 1; break; end
        end
        xfer_req  = 1'b0;
        end_cond  = 1'b0;
        bus_ready = 1'b0;
        check(!timeout, "R10 channel reaches idle", int'(timeout), 0);
        check(wr == int'(v.exp_w), "R5 transfers completed", wr, int'(v.exp_w));
        check(stop_flag == v.exp_stk, "R4 stop_flag", int'(stop_flag), int'(v.exp_stk));
        check(rd == wr, "R6 writes match reads", wr, rd);
        check(bad_addr == 0, "R8 address sequence", bad_addr, 0);
        check(bad_gap == 0, "R9 bus released after write", bad_gap, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int busy;
        rst        = 1'b1;
        en         = 1'b0;
        burst_mode = 1'b0;
        level_mode = 1'b1;
        xfer_req   = 1'b0;
        end_cond   = 1'b0;
        count_init = '0;
        src_base   = SRC0;
        dst_base   = DST0;
        bus_ready  = 1'b0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(idle == 1'b1, "R11 idle in reset", int'(idle), 1);
        check(bus_req == 1'b0, "R11 bus_req in reset", int'(bus_req), 0);
        check(stop_flag == 1'b0, "R11 stop_flag in reset", int'(stop_flag), 0);
        rst = 1'b0;
        @(negedge clk);
        check(idle == 1'b1 && bus_req == 1'b0, "R11 after reset", int'(idle), 1);

        foreach (VECS[i]) run_case(VECS[i]);

        // R7: after count exhaustion end_cond and requests are ignored
        run_case(VECS[0]);
        busy = 0;
        end_cond = 1'b1;
        xfer_req = 1'b1;
        @(negedge clk);
        end_cond = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (bus_req) busy++;
        end
        xfer_req = 1'b0;
        check(stop_flag == 1'b0, "R7 flag stays clear after count", int'(stop_flag), 0);
        check(busy == 0 && idle, "R7 no bus activity after count", busy, 0);

        // R10: sticky flag holds while idle and disabled
        run_case(VECS[8]);
        repeat (3) @(negedge clk);
        check(stop_flag == 1'b1, "R10 stop_flag held", int'(stop_flag), 1);

        // R1: re-enable clears the flag and leaves idle
        level_mode = 1'b1;
        burst_mode = 1'b0;
        count_init = 8'd3;
        xfer_req   = 1'b0;
        en         = 1'b1;
        @(negedge clk);
        check(stop_flag == 1'b0, "R1 flag cleared on start", int'(stop_flag), 0);
        check(idle == 1'b0, "R1 active after start", int'(idle), 0);

        // R4: end condition before any request gives no transfer
        busy = 0;
        end_cond = 1'b1;
        @(negedge clk);
        end_cond = 1'b0;
        xfer_req = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (bus_req) busy++;
        end
        xfer_req = 1'b0;
        check(busy == 0, "R4 no transfer after stop", busy, 0);
        check(idle == 1'b1 && stop_flag == 1'b1, "R4 idle with flag", int'(stop_flag), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule